// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block decides, at each instruction boundary, whether the processor should leave its current flow for an interrupt handler. Three hardware sources are handled: the timer0/real-time source, the timer1 source and the external event source. Each request line is edge-latched into a pending bit, gated by a per-source enable, and a single global mask flag holds back all hardware requests while a handler runs. A software interrupt request from the current instruction is also accepted.

Once a source is chosen, the controller saves the return context on the data stack, one byte per cycle. It saves the low PC byte, then the high PC byte, then the program page, then the status byte, with the stack address falling by one after each byte. It then sets the mask and presents the 20-bit handler address, which is always in page 3. A return request runs the sequence in reverse. It reads the four bytes back from rising stack addresses and presents the restored status, page and PC. It also clears the mask. The core supplies the stack pointer at the start of each sequence and takes the new value from `sp_o` when the load strobe fires.

Top module: `irq_entry_ctrl`

## Requirements
- R1: The enable register has bit0 for timer0/real-time, bit1 for timer1 and bit2 for external. A write replaces all three bits, and all three bits are 0 after reset.
- R2: A rising edge on a request line sets that source's pending bit whether or not the source is enabled. The bit stays set until that source is serviced, so a request that arrives while its source is disabled is taken later, once it is enabled.
- R3: Arbitration happens only in a cycle where `boundary_i` is high and no sequence is running. Among sources that are both pending and enabled, bit0 wins over bit1, and bit1 wins over bit2.
- R4: The handler addresses are all in page 3. The PC offsets are 0x3FF0 for timer0/real-time, 0x3FE0 for timer1, 0x3FD0 for external and 0x3FC0 for software. `load_pc_o` and `load_page_o` are valid while `load_o` is high, and `load_o` is high for exactly one cycle.
- R5: Entry writes four bytes. PC[7:0] goes to address sp, the zero-extended PC[13:8] to sp-1, the zero-extended page to sp-2 and the status byte to sp-3. After entry, `sp_o` = sp-4.
- R6: Entry sets `mask_o`. While `mask_o` is set, no hardware source is taken, and its pending bit is kept.
- R7: A software request (`swi_i` at a boundary) is taken even while `mask_o` is set, and it wins over any hardware source at the same boundary. A return request wins over both.
- R8: Return reads addresses sp+1, sp+2, sp+3 and sp+4, in that order, as status, page, PC high and PC low. `stk_rdata_i` must hold the byte at `stk_addr_o` in the same cycle. Return presents `status_o` with `status_we_o`, the page and the 14-bit PC, sets `sp_o` = sp+4 and clears `mask_o`.
- R9: Call the clock edge that accepts a boundary E0. The stack strobes are active for the four cycles after E0. `busy_o` is high in those four cycles. `load_o` rises after the fourth edge after E0.
- R10: After reset, `mask_o`, `busy_o`, `load_o`, `status_we_o`, `stk_we_o` and `stk_re_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 3 | Hardware request lines; bit0 timer0/real-time, bit1 timer1, bit2 external |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 3 | Enable register write data |
| boundary_i | input | 1 | Instruction boundary strobe |
| swi_i | input | 1 | Software interrupt request, qualified by boundary |
| ret_i | input | 1 | Return request, qualified by boundary |
| pc_i | input | 14 | Current program counter |
| page_i | input | 6 | Current program page |
| status_i | input | 8 | Current status byte |
| sp_i | input | 8 | Current stack pointer |
| stk_we_o | output | 1 | Stack byte write strobe |
| stk_re_o | output | 1 | Stack byte read strobe |
| stk_addr_o | output | 8 | Stack byte address |
| stk_wdata_o | output | 8 | Stack byte write data |
| stk_rdata_i | input | 8 | Stack byte at stk_addr_o, same cycle |
| load_o | output | 1 | One-cycle strobe: load PC, page and SP |
| load_pc_o | output | 14 | PC to load |
| load_page_o | output | 6 | Page to load into program page and page register |
| status_we_o | output | 1 | One-cycle strobe: restore status |
| status_o | output | 8 | Restored status byte |
| sp_o | output | 8 | Stack pointer after the sequence |
| mask_o | output | 1 | Global interrupt mask flag |
| busy_o | output | 1 | A sequence is running |

## Verification
A boundary is driven on a falling edge and is accepted on the next rising edge, E0. The bench then checks `busy_o` on the falling edge right after E0. It checks on the third falling edge after that one that `load_o` is still low. On the next falling edge it checks the load strobe, the vector or restored context, `sp_o`, `mask_o` and the four stack bytes. One cycle later it confirms that the strobe has dropped. Request pulses last one cycle, and the pending bit is in place by the next edge. Expected vectors and priorities come from a bench model that tracks the enables, the pending bits, the mask and a stack of saved contexts.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_POP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] elig_o
);
  logic [NSRC-1:0] req_q, pend_q, en_q, rise;

  assign rise   = req_i & ~req_q;
  assign elig_o = pend_q & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_i) | rise;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  // R2/R3: at most one source is cleared per acceptance
  a_r3_one_clear: assert property (@(posedge clk) disable iff (rst) $onehot0(clr_i));

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    // R2: an edge is latched into the pending bit
    a_r2_latch: assert property (@(posedge clk) disable iff (rst)
      (rise[g] && !clr_i[g]) |=> pend_q[g]);
    // R2: servicing clears the pending bit
    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !rise[g]) |=> !pend_q[g]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 3,
  parameter int IW   = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0] elig_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o,
  output logic [NSRC-1:0] grant_o
);
  always_comb begin
    any_o   = 1'b0;
    idx_o   = '0;
    grant_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        any_o      = 1'b1;
        idx_o      = IW'(i);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int            NSRC      = 3,
  parameter int            IW        = $clog2(NSRC + 1),
  parameter int            AW        = 14,
  parameter int            PW        = 6,
  parameter int            DW        = 8,
  parameter int            SPW       = 8,
  parameter int            VEC_SHIFT = 4,
  parameter logic [AW-1:0] VEC_TOP   = 14'h3FF0,
  parameter logic [PW-1:0] VEC_PAGE  = 6'd3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            boundary_i,
  input  logic            swi_i,
  input  logic            ret_i,
  input  logic            hw_any_i,
  input  logic [IW-1:0]   hw_idx_i,
  input  logic [NSRC-1:0] hw_grant_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [PW-1:0]   page_i,
  input  logic [DW-1:0]   status_i,
  input  logic [SPW-1:0]  sp_i,
  input  logic [DW-1:0]   stk_rdata_i,
  output logic [NSRC-1:0] clr_o,
  output logic            stk_we_o,
  output logic            stk_re_o,
  output logic [SPW-1:0]  stk_addr_o,
  output logic [DW-1:0]   stk_wdata_o,
  output logic            load_o,
  output logic [AW-1:0]   load_pc_o,
  output logic [PW-1:0]   load_page_o,
  output logic            status_we_o,
  output logic [DW-1:0]   status_o,
  output logic [SPW-1:0]  sp_o,
  output logic            mask_o,
  output logic            busy_o
);
  seq_state_t     state_q;
  logic [1:0]     cnt_q;
  logic [SPW-1:0] sp_q;
  logic [DW-1:0]  ctx_hi, ctx_pg, ctx_st;
  logic [AW-1:0]  vec_q, vec_c;
  logic           idle, take_ret, take_sw, take_hw;
  logic [IW-1:0]  sel_idx;

  assign idle     = (state_q == SEQ_IDLE);
  assign take_ret = idle && boundary_i && ret_i;
  assign take_sw  = idle && boundary_i && !ret_i && swi_i;
  assign take_hw  = idle && boundary_i && !ret_i && !swi_i && hw_any_i && !mask_o;
  assign clr_o    = take_hw ? hw_grant_i : '0;
  assign sel_idx  = take_sw ? IW'(NSRC) : hw_idx_i;
  assign vec_c    = VEC_TOP - (AW'(sel_idx) << VEC_SHIFT);
  assign busy_o   = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SEQ_IDLE;
      cnt_q       <= '0;
      sp_q        <= '0;
      ctx_hi      <= '0;
      ctx_pg      <= '0;
      ctx_st      <= '0;
      vec_q       <= '0;
      stk_we_o    <= 1'b0;
      stk_re_o    <= 1'b0;
      stk_addr_o  <= '0;
      stk_wdata_o <= '0;
      load_o      <= 1'b0;
      load_pc_o   <= '0;
      load_page_o <= '0;
      status_we_o <= 1'b0;
      status_o    <= '0;
      sp_o        <= '0;
      mask_o      <= 1'b0;
    end else begin
      load_o      <= 1'b0;
      status_we_o <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          cnt_q <= '0;
          if (take_ret) begin
            state_q    <= SEQ_POP;
            stk_re_o   <= 1'b1;
            stk_addr_o <= sp_i + 1'b1;
            sp_q       <= sp_i + 1'b1;
          end else if (take_sw || take_hw) begin
            state_q     <= SEQ_PUSH;
            stk_we_o    <= 1'b1;
            stk_addr_o  <= sp_i;
            stk_wdata_o <= pc_i[DW-1:0];
            sp_q        <= sp_i - 1'b1;
            ctx_hi      <= {{(2*DW-AW){1'b0}}, pc_i[AW-1:DW]};
            ctx_pg      <= {{(DW-PW){1'b0}}, page_i};
            ctx_st      <= status_i;
            vec_q       <= vec_c;
          end
        end
        SEQ_PUSH: begin
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == 2'd3) begin
            state_q     <= SEQ_IDLE;
            stk_we_o    <= 1'b0;
            load_o      <= 1'b1;
            load_pc_o   <= vec_q;
            load_page_o <= VEC_PAGE;
            sp_o        <= sp_q;
            mask_o      <= 1'b1;
          end else begin
            stk_addr_o <= sp_q;
            sp_q       <= sp_q - 1'b1;
            case (cnt_q)
              2'd0:    stk_wdata_o <= ctx_hi;
              2'd1:    stk_wdata_o <= ctx_pg;
              default: stk_wdata_o <= ctx_st;
            endcase
          end
        end
        SEQ_POP: begin
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == 2'd3) begin
            state_q     <= SEQ_IDLE;
            stk_re_o    <= 1'b0;
            load_o      <= 1'b1;
            load_pc_o   <= {ctx_hi[AW-DW-1:0], stk_rdata_i};
            load_page_o <= ctx_pg[PW-1:0];
            status_o    <= ctx_st;
            status_we_o <= 1'b1;
            sp_o        <= sp_q;
            mask_o      <= 1'b0;
          end else begin
            stk_addr_o <= sp_q + 1'b1;
            sp_q       <= sp_q + 1'b1;
            case (cnt_q)
              2'd0:    ctx_st <= stk_rdata_i;
              2'd1:    ctx_pg <= stk_rdata_i;
              default: ctx_hi <= stk_rdata_i;
            endcase
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R5: consecutive pushes walk the stack downward
  a_r5_push_down: assert property (@(posedge clk) disable iff (rst)
    (stk_we_o && $past(stk_we_o)) |-> (stk_addr_o == $past(stk_addr_o) - 1'b1));
  // R8: consecutive pops walk the stack upward
  a_r8_pop_up: assert property (@(posedge clk) disable iff (rst)
    (stk_re_o && $past(stk_re_o)) |-> (stk_addr_o == $past(stk_addr_o) + 1'b1));
  // R6/R9: the last push is followed by the load strobe with the mask set
  a_r6_mask_on_entry: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_PUSH && cnt_q == 2'd3) |=> (load_o && mask_o && !status_we_o));
  // R8: the last pop is followed by the restore strobes with the mask clear
  a_r8_restore: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_POP && cnt_q == 2'd3) |=> (load_o && status_we_o && !mask_o));
  // R9: the stack is never read and written together
  a_r9_no_rw: assert property (@(posedge clk) disable iff (rst) !(stk_we_o && stk_re_o));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int NSRC = 3,
  parameter int AW   = 14,
  parameter int PW   = 6,
  parameter int DW   = 8,
  parameter int SPW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic            boundary_i,
  input  logic            swi_i,
  input  logic            ret_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [PW-1:0]   page_i,
  input  logic [DW-1:0]   status_i,
  input  logic [SPW-1:0]  sp_i,
  output logic            stk_we_o,
  output logic            stk_re_o,
  output logic [SPW-1:0]  stk_addr_o,
  output logic [DW-1:0]   stk_wdata_o,
  input  logic [DW-1:0]   stk_rdata_i,
  output logic            load_o,
  output logic [AW-1:0]   load_pc_o,
  output logic [PW-1:0]   load_page_o,
  output logic            status_we_o,
  output logic [DW-1:0]   status_o,
  output logic [SPW-1:0]  sp_o,
  output logic            mask_o,
  output logic            busy_o
);
  localparam int IW = $clog2(NSRC + 1);

  logic [NSRC-1:0] elig, grant, clr;
  logic            hw_any;
  logic [IW-1:0]   hw_idx;

  irq_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req_i(req_i), .en_we_i(en_we_i),
    .en_wdata_i(en_wdata_i), .clr_i(clr), .elig_o(elig)
  );

  irq_arbiter #(.NSRC(NSRC), .IW(IW)) u_arb (
    .elig_i(elig), .any_o(hw_any), .idx_o(hw_idx), .grant_o(grant)
  );

  irq_seq #(.NSRC(NSRC), .IW(IW), .AW(AW), .PW(PW), .DW(DW), .SPW(SPW)) u_seq (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .swi_i(swi_i), .ret_i(ret_i),
    .hw_any_i(hw_any), .hw_idx_i(hw_idx), .hw_grant_i(grant),
    .pc_i(pc_i), .page_i(page_i), .status_i(status_i), .sp_i(sp_i),
    .stk_rdata_i(stk_rdata_i), .clr_o(clr),
    .stk_we_o(stk_we_o), .stk_re_o(stk_re_o), .stk_addr_o(stk_addr_o),
    .stk_wdata_o(stk_wdata_o), .load_o(load_o), .load_pc_o(load_pc_o),
    .load_page_o(load_page_o), .status_we_o(status_we_o), .status_o(status_o),
    .sp_o(sp_o), .mask_o(mask_o), .busy_o(busy_o)
  );
endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NONE = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  req = '0;
  logic        en_we = 1'b0;
  logic [2:0]  en_wdata = '0;
  logic        boundary = 1'b0, swi = 1'b0, ret = 1'b0;
  logic [13:0] pc = '0;
  logic [5:0]  page = '0;
  logic [7:0]  status = '0, sp = 8'hFF;
  logic        stk_we, stk_re, load, status_we, mask, busy;
  logic [7:0]  stk_addr, stk_wdata, stk_rdata, status_o, sp_o;
  logic [13:0] load_pc;
  logic [5:0]  load_page;

  logic [7:0]  mem [256];
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  logic [2:0]  en_m = '0, pend_m = '0;
  logic        mask_m = 1'b0;
  logic [13:0] sv_pc [8];
  logic [5:0]  sv_pg [8];
  logic [7:0]  sv_st [8];
  int          depth = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_ctrl i_irq_entry_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .en_we_i(en_we), .en_wdata_i(en_wdata),
    .boundary_i(boundary), .swi_i(swi), .ret_i(ret), .pc_i(pc), .page_i(page),
    .status_i(status), .sp_i(sp), .stk_we_o(stk_we), .stk_re_o(stk_re),
    .stk_addr_o(stk_addr), .stk_wdata_o(stk_wdata), .stk_rdata_i(stk_rdata),
    .load_o(load), .load_pc_o(load_pc), .load_page_o(load_page),
    .status_we_o(status_we), .status_o(status_o), .sp_o(sp_o),
    .mask_o(mask), .busy_o(busy)
  );

  always @(posedge clk) if (stk_we) mem[stk_addr] <= stk_wdata;
  assign stk_rdata = mem[stk_addr];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [13:0] vec_of(input int idx);
    return 14'h3FF0 - 14'(idx * 16);
  endfunction

  function automatic int pick(input bit use_swi);
    if (use_swi) return 3;
    if (mask_m) return NONE;
    for (int i = 0; i < 3; i++) if (pend_m[i] && en_m[i]) return i;
    return NONE;
  endfunction

  task automatic write_en(input logic [2:0] v);
    en_we = 1'b1; en_wdata = v; tick();
    en_we = 1'b0; en_m = v;
  endtask

  task automatic pulse_req(input logic [2:0] v);
    req = v; tick();
    req = '0; tick();
    pend_m |= v;
  endtask

  task automatic randomize_ctx();
    pc = 14'($urandom); page = 6'($urandom); status = 8'($urandom);
  endtask

  // entry, expected source idx (3 = software)
  task automatic run_entry(input int idx);
    logic [7:0] sp0 = sp;
    boundary = 1'b1; swi = (idx == 3);
    tick();
    boundary = 1'b0; swi = 1'b0;
    check(busy === 1'b1, "R9 busy after accept", busy, 1);
    tick(); tick(); tick();
    check(load === 1'b0, "R9 load not early", load, 0);
    tick();
    check(load === 1'b1, "R9 load strobe", load, 1);
    check(load_pc === vec_of(idx), "R4 vector pc", load_pc, vec_of(idx));
    check(load_page === 6'd3, "R4 vector page", load_page, 3);
    check(sp_o === sp0 - 8'd4, "R5 sp after entry", sp_o, sp0 - 8'd4);
    check(mask === 1'b1, "R6 mask set", mask, 1);
    check(mem[sp0] === pc[7:0], "R5 pc low at sp", mem[sp0], pc[7:0]);
    check(mem[8'(sp0-1)] === {2'b0, pc[13:8]}, "R5 pc high", mem[8'(sp0-1)], {2'b0, pc[13:8]});
    check(mem[8'(sp0-2)] === {2'b0, page}, "R5 page", mem[8'(sp0-2)], {2'b0, page});
    check(mem[8'(sp0-3)] === status, "R5 status", mem[8'(sp0-3)], status);
    sv_pc[depth] = pc; sv_pg[depth] = page; sv_st[depth] = status; depth++;
    if (idx < 3) pend_m[idx] = 1'b0;
    mask_m = 1'b1;
    sp = sp_o;
    tick();
    check(load === 1'b0, "R4 load one cycle", load, 0);
  endtask

  task automatic run_none(input bit use_swi);
    boundary = 1'b1; swi = use_swi;
    tick();
    boundary = 1'b0; swi = 1'b0;
    check(busy === 1'b0, "R3/R6 no acceptance", busy, 0);
    tick(); tick(); tick(); tick();
    check(load === 1'b0, "R3/R6 no load", load, 0);
  endtask

  task automatic run_return();
    logic [7:0] sp0 = sp;
    depth--;
    randomize_ctx();
    boundary = 1'b1; ret = 1'b1;
    tick();
    boundary = 1'b0; ret = 1'b0;
    check(busy === 1'b1, "R9 busy on return", busy, 1);
    tick(); tick(); tick(); tick();
    check(load === 1'b1 && status_we === 1'b1, "R8 restore strobes", {load, status_we}, 2'b11);
    check(load_pc === sv_pc[depth], "R8 pc restored", load_pc, sv_pc[depth]);
    check(load_page === sv_pg[depth], "R8 page restored", load_page, sv_pg[depth]);
    check(status_o === sv_st[depth], "R8 status restored", status_o, sv_st[depth]);
    check(sp_o === sp0 + 8'd4, "R8 sp after return", sp_o, sp0 + 8'd4);
    check(mask === 1'b0, "R8 mask cleared", mask, 0);
    mask_m = 1'b0;
    sp = sp_o;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R10 reset state
    check(mask === 1'b0 && busy === 1'b0, "R10 mask/busy", {mask, busy}, 0);
    check(load === 1'b0 && status_we === 1'b0, "R10 strobes", {load, status_we}, 0);
    check(stk_we === 1'b0 && stk_re === 1'b0, "R10 stack strobes", {stk_we, stk_re}, 0);

    // R1: enables reset to 0, disabled pending is kept (R2)
    pulse_req(3'b001);
    run_none(1'b0);
    write_en(3'b001);
    randomize_ctx();
    run_entry(0);
    run_return();

    // R3 priority among pending sources
    write_en(3'b111);
    pulse_req(3'b110);
    randomize_ctx(); run_entry(1); run_return();
    randomize_ctx(); run_entry(2); run_return();
    pulse_req(3'b111);
    randomize_ctx(); run_entry(0); run_return();
    randomize_ctx(); run_entry(1); run_return();
    randomize_ctx(); run_entry(2); run_return();

    // R1 write replaces: disable bit0 only
    write_en(3'b110);
    pulse_req(3'b101);
    randomize_ctx(); run_entry(2); run_return();
    run_none(1'b0);
    write_en(3'b111);
    randomize_ctx(); run_entry(0); run_return();

    // R6 masking, R7 software while masked, nested return
    pulse_req(3'b100);
    randomize_ctx(); run_entry(2);
    pulse_req(3'b001);
    run_none(1'b0);
    randomize_ctx(); run_entry(3);
    run_return();
    run_return();
    randomize_ctx(); run_entry(0); run_return();

    // R7 software wins over an eligible hardware source
    pulse_req(3'b010);
    randomize_ctx(); run_entry(3); run_return();
    randomize_ctx(); run_entry(1); run_return();

    // random mix
    for (int it = 0; it < 60; it++) begin
      int e;
      bit s;
      write_en(3'($urandom));
      pulse_req(3'($urandom));
      sp = 8'($urandom);
      randomize_ctx();
      s = ($urandom % 4) == 0;
      e = pick(s);
      if (e == NONE) run_none(1'b0);
      else begin
        run_entry(e);
        run_return();
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule